// File: doc/BRIEF.md
# Vector Memory Reference Address Sequencer

This block produces the word addresses of a single vector memory reference, one address per cycle. A request gives a mode, a 32-bit base, a 32-bit stride and a 6-bit element count. The block then walks the elements in order and presents each address with its element index on a valid/ready channel toward the memory port. Addresses are counted in 64-bit words.

Three address modes share one sequencer. In stride mode, each element address is the base plus the element index times a signed stride. In index mode (gather or scatter), each element address is the base plus a per-element offset. The offset comes from the vector operand that feeds the block through `off_i`. The block shows the element whose offset it needs on `elem_o`, and `off_i` must carry that element's offset in the same cycle. In local mode the stride is fixed at one and the target is a 16K-word scratch memory. Only the low 14 address bits are driven, and an address past the end of that memory sets an error flag. The block refuses a new request while a sequence is running, and it pulses `done_o` once a sequence completes.

Top module: `vag_top`

## Requirements
- R1: After reset, `req_ready_o` is 1, `addr_valid_o` is 0 and `done_o` is 0.
- R2: A request is taken only in a cycle where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` is 0 while a sequence is active. A request presented while the block is busy has no effect on the addresses produced.
- R3: In stride mode (`req_mode_i` = 0), element n has address (base + n*stride) mod 2^32, with the stride taken as two's complement.
- R4: In index mode (`req_mode_i` = 1), element n has address (base + off_i) mod 2^32, where `off_i` is sampled while `elem_o` = n.
- R5: In local mode (`req_mode_i` = 2), let raw = (base + n) mod 2^32. `addr_o` carries raw[13:0] with bits 31:14 at zero. `lm_err_o` is 1 exactly when raw >= 16384.
- R6: A length of L in 1..63 produces L addresses, and a length of 0 produces 64. `elem_o` starts at 0, and `last_o` is 1 only on the final element.
- R7: While `addr_valid_o` is 1 and `addr_ready_i` is 0, the next cycle keeps `addr_valid_o` at 1 with `addr_o` and `elem_o` unchanged.
- R8: `done_o` is a one-cycle pulse. It appears in the cycle after the last address is accepted, and `addr_valid_o` is 0 in that cycle.
- R9: `elem_o` advances by one only on an accepted address (`addr_valid_o` and `addr_ready_i`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_mode_i | input | 2 | 0 stride, 1 index, 2 local |
| req_base_i | input | 32 | Base word address |
| req_stride_i | input | 32 | Signed stride (stride mode only) |
| req_len_i | input | 6 | Element count, 0 means 64 |
| off_i | input | 32 | Offset for element `elem_o` (index mode) |
| addr_valid_o | output | 1 | Address valid |
| addr_ready_i | input | 1 | Memory port accepts address |
| addr_o | output | 32 | Word address |
| elem_o | output | 6 | Element index of `addr_o` |
| last_o | output | 1 | Final element of the sequence |
| lm_err_o | output | 1 | Local address out of range |
| done_o | output | 1 | Sequence complete pulse |

## Verification
The hold property assumes that `off_i` depends only on `elem_o`, so an address in index mode stays stable while it is stalled. The bench drives `off_i` from a table indexed by `elem_o` and changes the table only between sequences. The checks also assume that mode code 3 is never used, and every request in the stimulus uses mode 0, 1 or 2. The bench mixes random stalls into `addr_ready_i` and forces longer stalls, so the hold and backpressure rules are exercised under real stalls.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [1:0] {
    MODE_STRIDE = 2'd0,
    MODE_INDEX  = 2'd1,
    MODE_LOCAL  = 2'd2
  } vag_mode_e;
endpackage

// File: rtl/vag_seq.sv
module vag_seq #(
  parameter int unsigned LW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  input  logic          fire_i,
  output logic          busy_o,
  output logic [LW-1:0] elem_o,
  output logic          last_o,
  output logic          done_o
);
  logic          busy_q, done_q;
  logic [LW-1:0] elem_q, len_q;

  // len 0 wraps to all-ones, so zero means full depth
  assign last_o = (elem_q == len_q - LW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      elem_q <= '0;
      len_q  <= '0;
    end else begin
      done_q <= fire_i && last_o;
      if (start_i) begin
        busy_q <= 1'b1;
        elem_q <= '0;
        len_q  <= len_i;
      end else if (fire_i) begin
        elem_q <= elem_q + LW'(1);
        if (last_o) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign elem_o = elem_q;
  assign done_o = done_q;
endmodule

// File: rtl/vag_addr.sv
module vag_addr
  import vag_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned LM_AW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  vag_mode_e     mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] stride_i,
  input  logic          fire_i,
  input  logic [AW-1:0] off_i,
  output logic [AW-1:0] addr_o,
  output logic          lm_err_o,
  output vag_mode_e     mode_o
);
  vag_mode_e     mode_q;
  logic [AW-1:0] base_q, step_q, acc_q, raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_STRIDE;
      base_q <= '0;
      step_q <= '0;
      acc_q  <= '0;
    end else if (start_i) begin
      mode_q <= mode_i;
      base_q <= base_i;
      acc_q  <= base_i;
      step_q <= (mode_i == MODE_LOCAL) ? AW'(1) : stride_i;
    end else if (fire_i) begin
      acc_q <= acc_q + step_q;
    end
  end

  always_comb begin
    raw      = (mode_q == MODE_INDEX) ? base_q + off_i : acc_q;
    addr_o   = raw;
    lm_err_o = 1'b0;
    if (mode_q == MODE_LOCAL) begin
      addr_o   = {{(AW-LM_AW){1'b0}}, raw[LM_AW-1:0]};
      lm_err_o = |raw[AW-1:LM_AW];
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/vag_top.sv
module vag_top
  import vag_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned LW    = 6,
  parameter int unsigned LM_AW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_mode_i,
  input  logic [AW-1:0] req_base_i,
  input  logic [AW-1:0] req_stride_i,
  input  logic [LW-1:0] req_len_i,
  input  logic [AW-1:0] off_i,
  output logic          addr_valid_o,
  input  logic          addr_ready_i,
  output logic [AW-1:0] addr_o,
  output logic [LW-1:0] elem_o,
  output logic          last_o,
  output logic          lm_err_o,
  output logic          done_o
);
  logic      busy, start, fire, err_raw;
  vag_mode_e mode_q;

  assign start = req_valid_i && !busy;
  assign fire  = busy && addr_ready_i;

  vag_seq #(.LW(LW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .len_i   (req_len_i),
    .fire_i  (fire),
    .busy_o  (busy),
    .elem_o  (elem_o),
    .last_o  (last_o),
    .done_o  (done_o)
  );

  vag_addr #(.AW(AW), .LM_AW(LM_AW)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .mode_i   (vag_mode_e'(req_mode_i)),
    .base_i   (req_base_i),
    .stride_i (req_stride_i),
    .fire_i   (fire),
    .off_i    (off_i),
    .addr_o   (addr_o),
    .lm_err_o (err_raw),
    .mode_o   (mode_q)
  );

  assign req_ready_o  = !busy;
  assign addr_valid_o = busy;
  assign lm_err_o     = busy && err_raw;
endmodule

// File: rtl/vag_checker.sv
module vag_checker
  import vag_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned LW    = 6,
  parameter int unsigned LM_AW = 14
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          addr_valid_o,
  input logic          addr_ready_i,
  input logic [AW-1:0] addr_o,
  input logic [LW-1:0] elem_o,
  input logic          last_o,
  input logic          lm_err_o,
  input logic          done_o,
  input vag_mode_e     mode_q
);
  logic fire;
  assign fire = addr_valid_o && addr_ready_i;

  assert_busy_refuse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> !req_ready_o);

  assert_local_upper_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && mode_q == MODE_LOCAL) |-> (addr_o[AW-1:LM_AW] == '0));

  assert_err_local_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lm_err_o |-> (addr_valid_o && mode_q == MODE_LOCAL));

  assert_first_elem_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_valid_o) |-> (elem_o == '0));

  assert_hold_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && !addr_ready_i) |=> (addr_valid_o && $stable(addr_o) && $stable(elem_o)));

  assert_done_after_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && last_o) |=> (done_o && !addr_valid_o));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_elem_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !last_o) |=> (addr_valid_o && elem_o == $past(elem_o) + LW'(1)));

  assert_elem_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && !addr_ready_i) |=> $stable(elem_o));
endmodule

bind vag_top vag_checker #(.AW(AW), .LW(LW), .LM_AW(LM_AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .addr_valid_o (addr_valid_o),
  .addr_ready_i (addr_ready_i),
  .addr_o       (addr_o),
  .elem_o       (elem_o),
  .last_o       (last_o),
  .lm_err_o     (lm_err_o),
  .done_o       (done_o),
  .mode_q       (mode_q)
);

// File: tb/vag_top_tb_top.sv
module vag_top_tb_top;
  typedef struct {
    logic [31:0] addr;
    logic [5:0]  elem;
    logic        last;
    logic        err;
    string       tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [1:0]  req_mode_i = '0;
  logic [31:0] req_base_i = '0;
  logic [31:0] req_stride_i = '0;
  logic [5:0]  req_len_i = '0;
  logic [31:0] off_i;
  logic        addr_valid_o;
  logic        addr_ready_i = 1'b0;
  logic [31:0] addr_o;
  logic [5:0]  elem_o;
  logic        last_o, lm_err_o, done_o;

  logic [31:0] off_mem [64];
  exp_t        sb_q [$];
  int          n_chk = 0, n_fail = 0, cyc = 0;
  bit          bp = 0, force_stall = 0, exp_done = 0, hold_pend = 0, mon_en = 0;
  logic [31:0] hold_addr;
  logic [5:0]  hold_elem;

  always #4 clk_i = ~clk_i;

  vag_top dut_i (.*);

  always_comb off_i = off_mem[elem_o];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // stall pattern toward the block
  always @(posedge clk_i) begin
    #2;
    addr_ready_i = force_stall ? 1'b0 : (bp ? (($urandom % 3) != 0) : 1'b1);
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      report();
    end
  end

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (mon_en) begin
      if (exp_done || done_o)
        check(done_o == exp_done, "R8", "done pulse", 32'(done_o), 32'(exp_done));
      if (hold_pend) begin
        check(addr_valid_o && addr_o == hold_addr, "R7", "stalled addr", addr_o, hold_addr);
        check(elem_o == hold_elem, "R7", "stalled elem", 32'(elem_o), 32'(hold_elem));
      end
      hold_pend = addr_valid_o && !addr_ready_i;
      hold_addr = addr_o;
      hold_elem = elem_o;
      exp_done  = addr_valid_o && addr_ready_i && last_o;
      if (addr_valid_o && addr_ready_i) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R2", "unexpected address", addr_o, 32'hx);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(addr_o == e.addr, e.tag, "addr", addr_o, e.addr);
          check(elem_o == e.elem, "R9", "elem", 32'(elem_o), 32'(e.elem));
          check(last_o == e.last, "R6", "last", 32'(last_o), 32'(e.last));
          check(lm_err_o == e.err, "R5", "lm_err", 32'(lm_err_o), 32'(e.err));
        end
      end
    end
  end

  task automatic push_exp(input logic [1:0] mode, input logic [31:0] base,
                          input logic [31:0] stride, input logic [5:0] len);
    int cnt;
    cnt = (len == 0) ? 64 : int'(len);
    for (int n = 0; n < cnt; n++) begin
      exp_t e;
      logic [31:0] raw;
      e.elem = 6'(n);
      e.last = (n == cnt - 1);
      e.err  = 1'b0;
      case (mode)
        2'd0: begin e.addr = base + stride * 32'(n); e.tag = "R3"; end
        2'd1: begin e.addr = base + off_mem[n]; e.tag = "R4"; end
        default: begin
          raw    = base + 32'(n);
          e.addr = {18'b0, raw[13:0]};
          e.err  = |raw[31:14];
          e.tag  = "R5";
        end
      endcase
      sb_q.push_back(e);
    end
  endtask

  task automatic issue(input logic [1:0] mode, input logic [31:0] base,
                       input logic [31:0] stride, input logic [5:0] len);
    while (!req_ready_o) begin @(posedge clk_i); #2; end
    push_exp(mode, base, stride, len);
    req_mode_i = mode; req_base_i = base; req_stride_i = stride; req_len_i = len;
    req_valid_i = 1'b1;
    @(posedge clk_i); #2;
    req_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && sb_q.size() != 0; i++) @(posedge clk_i);
    check(sb_q.size() == 0, "R6", "missing addresses", 32'(sb_q.size()), 32'd0);
    repeat (3) @(posedge clk_i);
    #2;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) off_mem[i] = 32'(i * 5);
    repeat (3) @(posedge clk_i);
    #2;
    // R1 reset state
    check(req_ready_o == 1'b1, "R1", "ready", 32'(req_ready_o), 32'd1);
    check(addr_valid_o == 1'b0, "R1", "valid", 32'(addr_valid_o), 32'd0);
    check(done_o == 1'b0, "R1", "done", 32'(done_o), 32'd0);
    rst_ni = 1'b1;
    @(posedge clk_i); #2;
    mon_en = 1;

    // R3 positive stride, no stalls
    issue(2'd0, 32'd100, 32'd3, 6'd5);
    wait_idle();
    // R3 negative stride wrapping below zero
    bp = 1;
    issue(2'd0, 32'd10, -32'sd7, 6'd8);
    wait_idle();
    // R6 length zero means 64, with stalls (R7)
    issue(2'd0, 32'hFFFF_FFF0, 32'd1, 6'd0);
    wait_idle();
    // R4 indexed with mixed-sign offsets
    for (int i = 0; i < 64; i++) off_mem[i] = (i % 2 == 1) ? -32'(i * 9) : 32'(i * 1000);
    issue(2'd1, 32'd5000, 32'hDEAD_BEEF, 6'd10);
    wait_idle();
    // R5 local across the 16K boundary
    issue(2'd2, 32'd16380, 32'd77, 6'd8);
    wait_idle();
    // R5 in range, R6 length one
    bp = 0;
    issue(2'd2, 32'd0, 32'd9, 6'd1);
    wait_idle();
    // R2 request while busy is refused
    force_stall = 1;
    issue(2'd0, 32'h1000, 32'd1, 6'd20);
    req_mode_i = 2'd2; req_base_i = 32'h5; req_len_i = 6'd3;
    req_valid_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      check(req_ready_o == 1'b0, "R2", "ready while busy", 32'(req_ready_o), 32'd0);
      @(posedge clk_i); #2;
    end
    req_valid_i = 1'b0;
    force_stall = 0;
    wait_idle();
    // back-to-back requests, R8 done between them
    bp = 1;
    issue(2'd0, 32'd7, 32'd2, 6'd1);
    issue(2'd1, 32'd0, 32'd0, 6'd63);
    issue(2'd2, 32'h3FF0, 32'd0, 6'd33);
    wait_idle();
    report();
  end
endmodule